// File: doc/BRIEF.md
# Stereo Ramped Volume Control with Soft Mute

This block sits in front of a stereo DAC and scales each channel's 24-bit two's-complement samples by a gain picked from a 6-bit level code. The gain never jumps. When the programmed level or the mute bit of a channel changes, that channel's working level walks toward the new target one 1 dB step at a time, with one step every eight accepted samples. Mute reuses the same walk: it ramps down to the silent code, and on release it ramps back up to the programmed code.

In zero-cross mode a step that is due is held back until the channel's own signal changes sign. A held step is forced through after 512 samples without a crossing. If both channels have a held step and both see a crossing on the same sample, only one of them may step. The grant alternates between left and right, starting with left after reset.

Each channel runs its own controller with three named states. HOLD means the level equals the target. HOLD moves to RAMP as soon as the target differs. RAMP counts samples. It returns to HOLD when the target is reached, and on the eighth sample it either steps (it stays in RAMP) or, in zero-cross mode, moves to ZCWAIT. ZCWAIT steps and moves back to RAMP on a granted crossing, on a timeout, or when zero-cross mode is switched off. It returns to HOLD if the target comes back to the current level.

Top module: `stereo_ramp_atten`

## Requirements
- R1: Level code 63 is 0 dB and each lower code is 1 dB quieter, down to code 1 at -62 dB. Code 0 gives an output of exactly 0. The gain for code c is fixed-point with 23 fractional bits: g(63)=2^23, g(c-1)=floor((g(c)*14952710 + 2^23)/2^24), and g(0)=0.
- R2: After reset `out_valid` is 0, both outputs are 0, both working levels are 63 and mute is off, so samples pass through unchanged.
- R3: One clock after `smp_valid` is high, `out_valid` is high and each output equals floor((x*g(L) + 2^22)/2^23), clamped to the signed 24-bit range. L is the channel's working level at the moment the sample is accepted. In any clock after a cycle without `smp_valid`, `out_valid` is 0.
- R4: The target is 0 when the channel's mute bit is 1, and the level code otherwise. While the working level differs from the target, it moves one code toward the target on every eighth accepted sample. The first step comes on the eighth sample after the difference appears. A new level applies from the following sample onward.
- R5: Setting a channel's mute bit ramps that channel to code 0 and keeps it there. Clearing the mute bit ramps the channel back to its programmed code.
- R6: With `zc_en` = 1, a step that is due is withheld until a sample whose bit 23 differs from bit 23 of the previous sample on the same channel. The step is taken on that crossing sample.
- R7: With `zc_en` = 1, a withheld step is taken on the 512th sample after it became due, even if no crossing has occurred.
- R8: When both channels have a withheld step and both cross on the same sample, only one channel steps. The first such grant after reset goes to left, and every step taken on a crossing passes the grant to the other channel. Each channel keeps its own counters and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Strobe: both sample inputs hold a new stereo sample |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| lvl_left | input | 6 | Left level code (63 = 0 dB, 0 = silent) |
| lvl_right | input | 6 | Right level code |
| mute_left | input | 1 | Left soft-mute request |
| mute_right | input | 1 | Right soft-mute request |
| zc_en | input | 1 | Zero-cross gating of level steps |
| out_valid | output | 1 | Outputs hold a new attenuated sample |
| out_left | output | 24 | Left attenuated sample |
| out_right | output | 24 | Right attenuated sample |

## Verification
An output is due one clock after its input strobe, and it is computed with the level that was in force before any step that the same sample triggers. The bench therefore reads the outputs at the falling edge that follows the strobe cycle, and it advances its level model only after computing the expected value for that sample. A step becomes visible on the first sample after the stepping one. The ramp, crossing, timeout and grant checks are therefore placed on that sample: for example, the 513th sample of a timeout wait, or the sample that follows a double crossing. Control inputs always change at least one clock before the next strobe, so every controller has already left HOLD when that strobe arrives.

// File: rtl/ramp_atten_pkg.sv
package ramp_atten_pkg;

    typedef enum logic [1:0] {
        LV_HOLD   = 2'd0,
        LV_RAMP   = 2'd1,
        LV_ZCWAIT = 2'd2
    } lv_state_e;

    // Gain for a level code: start at unity (2^frac) at the top code and
    // apply the rounded 1 dB multiplier once per code below it.
    function automatic longint unsigned gain_of(input int code, input int top,
                                                input int frac,
                                                input longint unsigned mul,
                                                input int mf);
        longint unsigned g;
        g = 64'd1 << frac;
        for (int k = top; k > code; k--) begin
            g = (g * mul + (64'd1 << (mf - 1))) >> mf;
        end
        if (code == 0) begin
            g = 64'd0;
        end
        return g;
    endfunction

endpackage

// File: rtl/ramp_level_ctrl.sv
module ramp_level_ctrl
    import ramp_atten_pkg::*;
#(
    parameter int LVL_W    = 6,
    parameter int STEP_SMP = 8,
    parameter int TMO_SMP  = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_sign,
    input  logic [LVL_W-1:0] target,
    input  logic             zc_en,
    input  logic             zc_grant,
    output logic             zc_want,
    output logic [LVL_W-1:0] level
);
    localparam int CNT_W = (STEP_SMP > 1) ? $clog2(STEP_SMP) : 1;
    localparam int TMO_W = (TMO_SMP > 1) ? $clog2(TMO_SMP) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_SMP - 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_SMP - 1);

    lv_state_e        st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic [TMO_W-1:0] tmo;
    logic             prev_sign;
    logic             differ;
    logic             zc_hit;
    logic             step;

    assign differ  = (target != level);
    assign zc_hit  = smp_sign ^ prev_sign;
    assign zc_want = (st == LV_ZCWAIT) && differ && smp_valid && zc_en && zc_hit;

    // next state and step decision
    always_comb begin
        st_nx = st;
        step  = 1'b0;
        unique case (st)
            LV_HOLD: begin
                if (differ) st_nx = LV_RAMP;
            end
            LV_RAMP: begin
                if (!differ) begin
                    st_nx = LV_HOLD;
                end else if (smp_valid && cnt == CNT_LAST) begin
                    if (zc_en) st_nx = LV_ZCWAIT;
                    else       step  = 1'b1;
                end
            end
            LV_ZCWAIT: begin
                if (!differ) begin
                    st_nx = LV_HOLD;
                end else if (smp_valid) begin
                    if (!zc_en || tmo == TMO_LAST || (zc_want && zc_grant)) begin
                        step  = 1'b1;
                        st_nx = LV_RAMP;
                    end
                end
            end
            default: st_nx = LV_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LV_HOLD;
        else        st <= st_nx;
    end

    // counters, sign history and working level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            tmo       <= '0;
            prev_sign <= 1'b0;
            level     <= '1;
        end else begin
            if (smp_valid) prev_sign <= smp_sign;
            if (st != LV_RAMP)  cnt <= '0;
            else if (smp_valid) cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
            if (st != LV_ZCWAIT) tmo <= '0;
            else if (smp_valid && tmo != TMO_LAST) tmo <= tmo + 1'b1;
            if (step) level <= (target > level) ? level + 1'b1 : level - 1'b1;
        end
    end

    AST_ONE_CODE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + 1'b1) || (level == $past(level) - 1'b1)); // R4
    AST_STEP_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> $past(smp_valid)); // R4
    AST_MUTE_FLOOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (target == '0 && level == '0) |=> (level == '0)); // R5
    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st != LV_ZCWAIT) |=> (tmo == '0)); // R7

endmodule

// File: rtl/gain_apply.sv
module gain_apply
    import ramp_atten_pkg::*;
#(
    parameter int              DATA_W   = 24,
    parameter int              LVL_W    = 6,
    parameter int              GAIN_F   = 23,
    parameter longint unsigned STEP_MUL = 64'd14952710,
    parameter int              STEP_F   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] x,
    input  logic [LVL_W-1:0]  code,
    output logic [DATA_W-1:0] y
);
    localparam int NLVL = 1 << LVL_W;
    localparam int GW   = GAIN_F + 1;
    localparam int PW   = DATA_W + GW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (GAIN_F - 1));
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] MINV = ~MAXV;

    logic [GW-1:0]          gtab [NLVL];
    logic [GW-1:0]          g;
    logic signed [PW-1:0]   prod, rnd, shd;
    logic [DATA_W-1:0]      y_n;

    for (genvar k = 0; k < NLVL; k++) begin : g_tab
        localparam longint unsigned GV = gain_of(k, NLVL - 1, GAIN_F, STEP_MUL, STEP_F);
        assign gtab[k] = GW'(GV);
    end

    assign g    = gtab[code];
    assign prod = PW'($signed(x)) * PW'($signed({1'b0, g}));
    assign rnd  = prod + HALF;
    assign shd  = rnd >>> GAIN_F;

    always_comb begin
        if (shd > MAXV)      y_n = MAXV[DATA_W-1:0];
        else if (shd < MINV) y_n = MINV[DATA_W-1:0];
        else                 y_n = shd[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        y <= '0;
        else if (in_valid) y <= y_n;
    end

    AST_SILENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code == '0) |=> (y == '0)); // R1

endmodule

// File: rtl/stereo_ramp_atten.sv
module stereo_ramp_atten
    import ramp_atten_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int LVL_W    = 6,
    parameter int STEP_SMP = 8,
    parameter int TMO_SMP  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_left,
    input  logic [DATA_W-1:0] smp_right,
    input  logic [LVL_W-1:0]  lvl_left,
    input  logic [LVL_W-1:0]  lvl_right,
    input  logic              mute_left,
    input  logic              mute_right,
    input  logic              zc_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    localparam int NCH = 2;

    logic [NCH-1:0][DATA_W-1:0] x_a, y_a;
    logic [NCH-1:0][LVL_W-1:0]  lvl_a, tgt_a, cur_a;
    logic [NCH-1:0]             mute_a, want_a, grant_a, take_a;
    logic                       turn;   // 0: left holds the grant, 1: right

    assign x_a    = {smp_right, smp_left};
    assign lvl_a  = {lvl_right, lvl_left};
    assign mute_a = {mute_right, mute_left};

    assign grant_a[0] = !want_a[1] || (turn == 1'b0);
    assign grant_a[1] = !want_a[0] || (turn == 1'b1);
    assign take_a     = want_a & grant_a;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign tgt_a[ch] = mute_a[ch] ? '0 : lvl_a[ch];

        ramp_level_ctrl #(
            .LVL_W    (LVL_W),
            .STEP_SMP (STEP_SMP),
            .TMO_SMP  (TMO_SMP)
        ) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp_sign  (x_a[ch][DATA_W-1]),
            .target    (tgt_a[ch]),
            .zc_en     (zc_en),
            .zc_grant  (grant_a[ch]),
            .zc_want   (want_a[ch]),
            .level     (cur_a[ch])
        );

        gain_apply #(
            .DATA_W (DATA_W),
            .LVL_W  (LVL_W)
        ) u_gain (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (smp_valid),
            .x        (x_a[ch]),
            .code     (cur_a[ch]),
            .y        (y_a[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            turn      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= smp_valid;
            if (take_a[0])      turn <= 1'b1;
            else if (take_a[1]) turn <= 1'b0;
        end
    end

    assign out_left  = y_a[0];
    assign out_right = y_a[1];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid); // R3
    AST_NO_IDLE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid); // R3
    AST_SINGLE_ZC_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_a)); // R8

endmodule

// File: tb/sim_stereo_ramp_atten.sv
module sim_stereo_ramp_atten;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [23:0] smp_left, smp_right;
    logic [5:0]  lvl_left, lvl_right;
    logic        mute_left, mute_right, zc_en;
    logic        out_valid;
    logic [23:0] out_left, out_right;

    always #5 clk = ~clk;

    stereo_ramp_atten u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right),
        .lvl_left(lvl_left), .lvl_right(lvl_right),
        .mute_left(mute_left), .mute_right(mute_right), .zc_en(zc_en),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    // stimulus table: lvl_left, lvl_right, mute_left, mute_right, samples
    localparam int NVEC = 7;
    localparam int VEC [NVEC][5] = '{
        '{60, 63, 0, 0,  30},
        '{63, 55, 0, 0,  70},
        '{63, 55, 1, 0, 520},
        '{40, 55, 0, 1, 460},
        '{ 1, 63, 0, 0, 520},
        '{63,  0, 0, 0, 520},
        '{63, 63, 0, 0, 520}
    };

    int          checks = 0;
    int          errors = 0;
    bit          done   = 0;
    longint      gt [64];
    int          m_cur [2];
    int          m_cnt [2];
    int          ol, orr;
    logic        ovl;
    logic [31:0] seed = 32'h1234_5678;

    function automatic string tag_of(input int i);
        case (i)
            0, 1:    return "R4";
            2, 3:    return "R5";
            4, 5:    return "R1";
            default: return "R3";
        endcase
    endfunction

    function automatic int mulref(input int x, input int code);
        longint p;
        p = longint'(x) * gt[code] + (longint'(1) <<< 22);
        p = p >>> 23;
        if (p > 8388607)  p = 8388607;
        if (p < -8388608) p = -8388608;
        return int'(p);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send(input int xl, input int xr);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = 24'(xl);
        smp_right = 24'(xr);
        @(negedge clk);
        smp_valid = 1'b0;
        ovl = out_valid;
        ol  = int'($signed(out_left));
        orr = int'($signed(out_right));
        @(negedge clk);
    endtask

    task automatic model_step(input int ch, input int tgt);
        if (m_cur[ch] == tgt) begin
            m_cnt[ch] = 0;
        end else if (m_cnt[ch] == 7) begin
            m_cur[ch] = (tgt > m_cur[ch]) ? m_cur[ch] + 1 : m_cur[ch] - 1;
            m_cnt[ch] = 0;
        end else begin
            m_cnt[ch]++;
        end
    endtask

    task automatic model_send(input int xl, input int xr, input string tag);
        int el, er;
        el = mulref(xl, m_cur[0]);
        er = mulref(xr, m_cur[1]);
        send(xl, xr);
        check("R3", "out_valid after strobe", int'(ovl), 1);
        check(tag, "left sample", ol, el);
        check(tag, "right sample", orr, er);
        model_step(0, mute_left  ? 0 : int'(lvl_left));
        model_step(1, mute_right ? 0 : int'(lvl_right));
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int xl, xr;
        gt[63] = longint'(1) <<< 23;
        for (int k = 63; k > 0; k--) gt[k-1] = (gt[k] * 14952710 + (longint'(1) <<< 23)) >>> 24;
        gt[0] = 0;

        rst_n = 1'b0; smp_valid = 1'b0; smp_left = '0; smp_right = '0;
        lvl_left = 6'd63; lvl_right = 6'd63; mute_left = 1'b0; mute_right = 1'b0; zc_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R2", "out_valid in reset", int'(out_valid), 0);
        check("R2", "left output in reset", int'($signed(out_left)), 0);
        check("R2", "right output in reset", int'($signed(out_right)), 0);
        rst_n = 1'b1;
        @(negedge clk);
        m_cur[0] = 63; m_cur[1] = 63; m_cnt[0] = 0; m_cnt[1] = 0;

        send(4242, -77);
        check("R2", "left passthrough at default level", ol, 4242);
        check("R2", "right passthrough at default level", orr, -77);
        check("R3", "out_valid low without strobe", int'(out_valid), 0);

        // table walk with the level model
        for (int i = 0; i < NVEC; i++) begin
            lvl_left   = 6'(VEC[i][0]);
            lvl_right  = 6'(VEC[i][1]);
            mute_left  = VEC[i][2] != 0;
            mute_right = VEC[i][3] != 0;
            @(negedge clk);
            for (int s = 0; s < VEC[i][4]; s++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                xl = int'($signed(seed[31:8]));
                seed = seed * 32'd1664525 + 32'd1013904223;
                xr = int'($signed(seed[31:8]));
                if (s % 41 == 5) xl = -8388608;
                if (s % 43 == 7) xr = 8388607;
                model_send(xl, xr, tag_of(i));
            end
        end

        // R6: step waits for a sign change
        zc_en = 1'b1;
        lvl_left = 6'd62;
        @(negedge clk);
        for (int s = 0; s < 13; s++) send(1000, 1000);
        check("R6", "left held at 0 dB without crossing", ol, 1000);
        send(-1000, -1000);
        check("R6", "crossing sample uses old level", ol, -1000);
        send(-1000, -1000);
        check("R6", "level 62 after crossing", ol, mulref(-1000, 62));

        // R7: forced step after 512 samples of waiting
        lvl_left = 6'd61;
        @(negedge clk);
        for (int s = 0; s < 8; s++) send(-1000, -1000);
        for (int s = 0; s < 511; s++) send(-1000, -1000);
        check("R7", "still level 62 at wait sample 511", ol, mulref(-1000, 62));
        send(-1000, -1000);
        check("R7", "timeout sample uses old level", ol, mulref(-1000, 62));
        send(-1000, -1000);
        check("R7", "level 61 after timeout", ol, mulref(-1000, 61));

        // R8: simultaneous crossings alternate, right owns the grant now
        lvl_left = 6'd60; lvl_right = 6'd62;
        @(negedge clk);
        for (int s = 0; s < 8; s++) send(-1000, -1000);
        send(1000, 1000);
        send(1000, 1000);
        check("R8", "right granted first double crossing", orr, mulref(1000, 62));
        check("R8", "left withheld on first double crossing", ol, mulref(1000, 61));
        lvl_right = 6'd61;
        @(negedge clk);
        for (int s = 0; s < 8; s++) send(1000, 1000);
        send(-1000, -1000);
        send(-1000, -1000);
        check("R8", "left granted second double crossing", ol, mulref(-1000, 60));
        check("R8", "right withheld on second double crossing", orr, mulref(-1000, 62));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule